// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control side of an 8-bit successive-approximation analog-to-digital converter. Software sees a small set of control fields: an enable, a start/busy bit, a two-bit bit-time clock select and a three-bit channel select. It also sees a result register that software may write and a sticky completion flag. When a conversion starts, the block opens the sample switch and drives trial codes to an external DAC. On each bit-time tick it samples the external comparator and resolves one bit, most significant first. It then commits the final code and raises the completion flag.

The bit-time tick comes from one of two places. It can be a divided system clock of 2, 8 or 32 cycles. It can also be the rising edge of a free-running asynchronous RC clock, which is first passed through a synchronizer. A conversion always lasts nine bit times: one to open the sample switch and eight to resolve bits. If software clears the start bit mid-conversion, the conversion is dropped without touching the result. A recovery wait of two bit times follows, and after it acquisition resumes by itself.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, enable, busy, done flag, sample output and result all read 0.
- R2: Clock select 00, 01 and 10 give a bit time of 2, 8 and 32 system clocks. Busy falls exactly 9 bit times after the clock edge that accepts the start write.
- R3: Clock select 11 takes each bit time from a rising edge of `rc_clk_i` after a two-flop synchronizer. A conversion completes on the ninth such edge after the start.
- R4: Trial codes start at 0x80 and bits are resolved MSB first. A comparator value of 1 (input at or above the trial code) keeps the trial bit and 0 clears it. The final code equals the binary-search result.
- R5: At normal completion, busy clears and the done flag is set. The done flag stays set until a flag write with data 0.
- R6: Clearing the start bit while busy aborts the conversion. The result keeps its previous value and the done flag is not set.
- R7: After an abort, `sample_o` stays low and starts are ignored for 2 bit times. After that `sample_o` returns high with no further write.
- R8: Software may write the result register, and a later completed conversion overwrites that value.
- R9: A control write that sets enable and start together, when the block was disabled, starts no conversion.
- R10: While enable is 0, start requests are ignored and `sample_o` is low.
- R11: The channel is latched at the start write. `chan_o` ignores channel writes until the conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable field written by ctl_we |
| ctl_go | input | 1 | Start field (1 starts, 0 aborts) |
| ctl_clk_sel | input | 2 | Bit-time source select |
| ctl_chan | input | 3 | Channel select |
| res_we | input | 1 | Result register write strobe |
| res_wdata | input | 8 | Result register write data |
| flag_we | input | 1 | Done-flag write strobe (data 0 clears) |
| flag_wdata | input | 1 | Done-flag write data |
| rc_clk_i | input | 1 | Asynchronous RC bit-time clock |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| en_o | output | 1 | Enable readback |
| busy_o | output | 1 | Start/busy readback |
| clk_sel_o | output | 2 | Clock-select readback |
| result_o | output | 8 | Result register |
| done_o | output | 1 | Sticky completion flag |
| dac_code_o | output | 8 | Trial code to the DAC |
| sample_o | output | 1 | Sample switch closed (acquiring) |
| chan_o | output | 3 | Channel routed to the analog mux |

## Verification
The bench builds the block with its default 8-bit width, 3-bit channel field and two synchronizer stages. This makes every divided bit time (2, 8, 32) reachable within a few hundred cycles, so exact completion and recovery edges can be checked for each divider. A behavioural comparator driven from `dac_code_o` lets codes such as 0x00, 0xFF, 0x80, 0x7F and 0xA5 exercise every keep/clear decision. A slow toggled RC input counts synchronized edges for the asynchronous source.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int DATA_W  = 8;
    localparam int CH_W    = 3;
    localparam int MAX_DIV = 32;
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_RECOV = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            en;
        logic            go;
        logic [1:0]      clk_sel;
        logic [CH_W-1:0] chan;
    } ctl_word_t;

    localparam logic [1:0] SEL_RC = 2'b11;

    // Bit-time length in system clocks for the divided sources.
    function automatic logic [CNT_W:0] div_of(input logic [1:0] sel);
        logic [CNT_W:0] r;
        case (sel)
            2'b00:   r = (CNT_W+1)'(2);
            2'b01:   r = (CNT_W+1)'(8);
            default: r = (CNT_W+1)'(MAX_DIV);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sar_rc_sync.sv
module sar_rc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
    import sar_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       rc_clk_i,
    output logic       tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             rc_rise;
    logic             div_tick;

    sar_rc_sync #(.STAGES(SYNC_STAGES)) rc_sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (rc_clk_i),
        .rise_o  (rc_rise)
    );

    assign last_cnt = CNT_W'(div_of(sel) - 1'b1);
    assign div_tick = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || clr || div_tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = !clr && ((sel == SEL_RC) ? rc_rise : div_tick);
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  ctl_word_t         ctl_w,
    input  logic              res_we,
    input  logic [DATA_W-1:0] res_wdata,
    input  logic              flag_we,
    input  logic              flag_wdata,
    input  logic              tick,
    input  logic              cmp_i,
    output logic              tick_clr,
    output logic              en_o,
    output logic              busy_o,
    output logic [1:0]        clk_sel_o,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              sample_o,
    output logic [CH_W-1:0]   chan_o
);
    localparam int TC_W = $clog2(DATA_W + 1);

    seq_state_e        state_q;
    logic              en_q;
    logic [1:0]        sel_q;
    logic [CH_W-1:0]   ch_q, ch_lat_q;
    logic [DATA_W-1:0] sar_q, result_q;
    logic              done_q;
    logic [TC_W-1:0]   tc_q;

    logic              en_next, start, abort, finish;
    logic [DATA_W-1:0] bit_msk, nxt_msk, resolved, sar_next;

    assign en_next = ctl_we ? ctl_w.en : en_q;
    assign start   = ctl_we && ctl_w.go && ctl_w.en && en_q && (state_q == ST_IDLE);
    assign abort   = (state_q == ST_CONV) && ctl_we && !ctl_w.go;
    assign finish  = (state_q == ST_CONV) && en_next && !abort && tick
                     && (tc_q == TC_W'(DATA_W));
    assign tick_clr = (state_q == ST_IDLE) || abort;

    // Select the bit under trial and the next bit to try from the tick count.
    always_comb begin
        bit_msk = '0;
        nxt_msk = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (TC_W'(DATA_W - i) == tc_q)     bit_msk[i] = 1'b1;
            if (TC_W'(DATA_W - 1 - i) == tc_q) nxt_msk[i] = 1'b1;
        end
        resolved = cmp_i ? sar_q : (sar_q & ~bit_msk);
        sar_next = resolved | nxt_msk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            sel_q    <= '0;
            ch_q     <= '0;
            ch_lat_q <= '0;
            sar_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            tc_q     <= '0;
            state_q  <= ST_IDLE;
        end else begin
            if (ctl_we) begin
                en_q  <= ctl_w.en;
                sel_q <= ctl_w.clk_sel;
                ch_q  <= ctl_w.chan;
            end
            if (finish)      result_q <= resolved;
            else if (res_we) result_q <= res_wdata;
            if (finish)                      done_q <= 1'b1;
            else if (flag_we && !flag_wdata) done_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_CONV;
                        tc_q     <= '0;
                        sar_q    <= {1'b1, {(DATA_W-1){1'b0}}};
                        ch_lat_q <= ctl_w.chan;
                    end
                end
                ST_CONV: begin
                    if (!en_next) begin
                        state_q <= ST_IDLE;
                    end else if (abort) begin
                        state_q <= ST_RECOV;
                        tc_q    <= '0;
                    end else if (tick) begin
                        sar_q <= sar_next;
                        tc_q  <= tc_q + 1'b1;
                        if (finish) state_q <= ST_IDLE;
                    end
                end
                ST_RECOV: begin
                    if (!en_next) begin
                        state_q <= ST_IDLE;
                    end else if (tick) begin
                        if (tc_q == TC_W'(1)) state_q <= ST_IDLE;
                        tc_q <= tc_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign en_o       = en_q;
    assign busy_o     = (state_q == ST_CONV);
    assign clk_sel_o  = sel_q;
    assign result_o   = result_q;
    assign done_o     = done_q;
    assign dac_code_o = sar_q;
    assign sample_o   = en_q && (state_q == ST_IDLE);
    assign chan_o     = (state_q == ST_CONV) ? ch_lat_q : ch_q;

    AST_START_NEEDS_PRIOR_EN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && $past(state_q) == ST_IDLE) |-> $past(en_q)); // R9
    AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOV && $past(state_q) == ST_CONV && !$past(res_we))
        |-> (result_q == $past(result_q) && !$rose(done_q))); // R6
    AST_RECOV_NO_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOV) |=> (state_q != ST_CONV)); // R7
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && $past(state_q) == ST_CONV) |-> $stable(ch_lat_q)); // R11
    AST_DONE_FROM_CONV: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(state_q) == ST_CONV && state_q == ST_IDLE)); // R5
    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic              ctl_en,
    input  logic              ctl_go,
    input  logic [1:0]        ctl_clk_sel,
    input  logic [CH_W-1:0]   ctl_chan,
    input  logic              res_we,
    input  logic [DATA_W-1:0] res_wdata,
    input  logic              flag_we,
    input  logic              flag_wdata,
    input  logic              rc_clk_i,
    input  logic              cmp_i,
    output logic              en_o,
    output logic              busy_o,
    output logic [1:0]        clk_sel_o,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              sample_o,
    output logic [CH_W-1:0]   chan_o
);
    ctl_word_t ctl_w;
    logic      tick, tick_clr;

    assign ctl_w = '{en: ctl_en, go: ctl_go, clk_sel: ctl_clk_sel, chan: ctl_chan};

    sar_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (tick_clr),
        .sel      (clk_sel_o),
        .rc_clk_i (rc_clk_i),
        .tick_o   (tick)
    );

    sar_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_w      (ctl_w),
        .res_we     (res_we),
        .res_wdata  (res_wdata),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .tick       (tick),
        .cmp_i      (cmp_i),
        .tick_clr   (tick_clr),
        .en_o       (en_o),
        .busy_o     (busy_o),
        .clk_sel_o  (clk_sel_o),
        .result_o   (result_o),
        .done_o     (done_o),
        .dac_code_o (dac_code_o),
        .sample_o   (sample_o),
        .chan_o     (chan_o)
    );
endmodule

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0, ctl_en = 1'b0, ctl_go = 1'b0;
    logic [1:0] ctl_clk_sel = 2'b00;
    logic [2:0] ctl_chan = 3'd0;
    logic       res_we = 1'b0;
    logic [7:0] res_wdata = 8'h00;
    logic       flag_we = 1'b0, flag_wdata = 1'b0;
    logic       rc_clk_i = 1'b0;
    logic       cmp_i;
    logic       en_o, busy_o, done_o, sample_o;
    logic [1:0] clk_sel_o;
    logic [7:0] result_o, dac_code_o;
    logic [2:0] chan_o;
    logic [7:0] vin = 8'h00;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Behavioural comparator: 1 when the analog input is at or above the trial code.
    assign cmp_i = (vin >= dac_code_o);

    sar_seq_top dut_i (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_go(ctl_go),
        .ctl_clk_sel(ctl_clk_sel), .ctl_chan(ctl_chan), .res_we(res_we),
        .res_wdata(res_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .rc_clk_i(rc_clk_i), .cmp_i(cmp_i), .en_o(en_o), .busy_o(busy_o),
        .clk_sel_o(clk_sel_o), .result_o(result_o), .done_o(done_o),
        .dac_code_o(dac_code_o), .sample_o(sample_o), .chan_o(chan_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Each write is presented for one edge; returns at the negedge after that edge.
    task automatic wr_ctl(input logic en, input logic go, input logic [1:0] cs, input logic [2:0] ch);
        @(negedge clk);
        ctl_we = 1'b1; ctl_en = en; ctl_go = go; ctl_clk_sel = cs; ctl_chan = ch;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_res(input logic [7:0] d);
        @(negedge clk); res_we = 1'b1; res_wdata = d;
        @(negedge clk); res_we = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_we = 1'b1; flag_wdata = 1'b0;
        @(negedge clk); flag_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 en", en_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 sample", sample_o, 0);
        chk("R1 result", result_o, 0);
    endtask

    task automatic t_divided(input logic [1:0] cs, input int n, input logic [7:0] v);
        vin = v;
        clr_flag();
        wr_ctl(1, 1, cs, 3'd1);
        chk("R4 first trial", dac_code_o, 8'h80);
        chk("R4 sample open", sample_o, 0);
        repeat (9*n - 1) @(negedge clk);
        chk("R2 busy before end", busy_o, 1);
        chk("R5 done before end", done_o, 0);
        @(negedge clk);
        chk("R2 busy at end", busy_o, 0);
        chk("R5 done set", done_o, 1);
        chk("R4 result", result_o, v);
        repeat (5) @(negedge clk);
        chk("R5 done sticky", done_o, 1);
        clr_flag();
        chk("R5 done cleared", done_o, 0);
    endtask

    task automatic rc_pulse();
        rc_clk_i = 1'b1; repeat (5) @(negedge clk);
        rc_clk_i = 1'b0; repeat (5) @(negedge clk);
    endtask

    task automatic t_rc();
        vin = 8'h5A;
        wr_ctl(1, 0, 2'b11, 3'd0);
        wr_ctl(1, 1, 2'b11, 3'd0);
        repeat (20) @(negedge clk);
        chk("R3 no tick without rc", busy_o, 1);
        repeat (8) rc_pulse();
        chk("R3 busy after 8 edges", busy_o, 1);
        rc_pulse();
        chk("R3 done after 9 edges", busy_o, 0);
        chk("R3 result", result_o, 8'h5A);
        clr_flag();
    endtask

    task automatic t_abort();
        vin = 8'hC3;
        wr_res(8'h11);
        wr_ctl(1, 0, 2'b00, 3'd0);
        wr_ctl(1, 1, 2'b00, 3'd0);
        repeat (7) @(negedge clk);
        wr_ctl(1, 0, 2'b00, 3'd0);          // abort at edge a
        chk("R6 busy cleared", busy_o, 0);
        chk("R6 result kept", result_o, 8'h11);
        chk("R7 sample low at a+1", sample_o, 0);
        // start attempt during recovery at edge a+1
        @(negedge clk); ctl_we = 1'b1; ctl_en = 1'b1; ctl_go = 1'b1;
        @(negedge clk); ctl_we = 1'b0;
        chk("R7 start ignored", busy_o, 0);
        @(negedge clk);
        chk("R7 sample low at a+3", sample_o, 0);
        @(negedge clk);
        chk("R7 sample back at a+4", sample_o, 1);
        repeat (30) @(negedge clk);
        chk("R6 done not set", done_o, 0);
        chk("R6 result still kept", result_o, 8'h11);
    endtask

    task automatic t_result_write();
        wr_res(8'h3C);
        chk("R8 sw write", result_o, 8'h3C);
        vin = 8'hA5;
        wr_ctl(1, 1, 2'b00, 3'd0);
        repeat (18) @(negedge clk);
        chk("R8 overwritten", result_o, 8'hA5);
        clr_flag();
    endtask

    task automatic t_same_write();
        wr_ctl(0, 0, 2'b00, 3'd0);
        chk("R10 sample low when off", sample_o, 0);
        wr_ctl(0, 1, 2'b00, 3'd0);
        chk("R10 start ignored when off", busy_o, 0);
        wr_ctl(1, 1, 2'b00, 3'd0);
        chk("R9 en+go same write", busy_o, 0);
        repeat (20) @(negedge clk);
        chk("R9 no completion", done_o, 0);
    endtask

    task automatic t_chan();
        vin = 8'h40;
        wr_ctl(1, 1, 2'b01, 3'd5);
        chk("R11 chan latched", chan_o, 3'd5);
        repeat (10) @(negedge clk);
        wr_ctl(1, 1, 2'b01, 3'd2);
        chk("R11 chan held mid", chan_o, 3'd5);
        chk("R11 still busy", busy_o, 1);
        repeat (70) @(negedge clk);
        chk("R11 conv ended", busy_o, 0);
        chk("R11 new chan after", chan_o, 3'd2);
        chk("R4 result 0x40", result_o, 8'h40);
        clr_flag();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        wr_ctl(1, 0, 2'b00, 3'd0);
        t_divided(2'b00, 2, 8'hA5);
        t_divided(2'b00, 2, 8'h00);
        t_divided(2'b01, 8, 8'hFF);
        t_divided(2'b10, 32, 8'h80);
        t_divided(2'b00, 2, 8'h7F);
        t_rc();
        t_abort();
        t_result_write();
        t_same_write();
        wr_ctl(1, 0, 2'b00, 3'd0);
        t_chan();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule